// File: doc/BRIEF.md
# CAN Transceiver Protection Controller

This block is the digital control core that sits between a host CAN controller and the analog driver and receiver of an isolated CAN transceiver. It receives the host transmit line, the sampled output of the receiver's differential comparator, two supply-good flags (one for the logic side and one for the bus side) and an over-temperature flag. From these it decides whether the bus driver may be used and whether it drives dominant. It also decides what the host sees on its receive line and whether that line is driven or left tristate.

Three separate fault sources can take the driver away, and each clears by its own rule. The first is a transmit line stuck dominant for too long, which clears once the line is seen recessive again. The second is over-temperature, which clears as soon as the flag drops. The third is a supply fault, which clears only after a recovery wait with both supplies good. The receive output does not treat the two supplies alike. A bad logic-side supply tristates it at once. A bad bus-side supply alone forces it high, but only after a fail-safe delay. Every duration is a parameter counted in clock cycles.

Top module: `can_guard_ctrl`

## Requirements
- R1: After reset, `drv_en` stays 0 and `rx_out` stays 1 (whatever the bus sample) until both supplies have been good for `REC_CYC` consecutive clock edges after reset release. On that edge `drv_en` becomes 1.
- R2: `tx_in` passes through a two-flop synchronizer. A change on `tx_in` reaches `drv_dominant` on the second rising clock edge after it is applied.
- R3: If the synchronized transmit line stays low (dominant) for `DTO_CYC` consecutive cycles, `drv_en` and `drv_dominant` go to 0 and `bus_bias_rec` goes to 1. After `DTO_CYC-1` low cycles the driver is still dominant.
- R4: The time-out clears once the synchronized transmit line is high again, so `drv_en` returns to 1 three edges after `tx_in` rises. A later low period gets a full new window of `DTO_CYC` cycles.
- R5: One edge after `overtemp` is set, `drv_en` is 0. One edge after it drops, the driver is usable again. It shuts down again if the flag comes back.
- R6: During a time-out or a thermal shutdown, `rx_out` keeps following the bus: a `bus_dom` value of 1 (dominant) gives `rx_out` 0.
- R7: When `logic_sup_ok` is 0, `rx_oe` is 0 in the same cycle (RXD tristate). One edge later the driver is disabled and the bus is held recessive.
- R8: When only `bus_sup_ok` is 0, the driver is off one edge later. `rx_out` keeps following the bus for `FS_CYC-1` edges and is forced to 1 on edge `FS_CYC`. `rx_oe` stays 1 throughout.
- R9: After a supply fault, the driver returns `REC_CYC` edges after both supplies are good again. Any supply drop during that wait restarts the full count.
- R10: With the driver enabled, a low synchronized transmit line gives `drv_dominant`=1 and `bus_bias_rec`=0. A high line gives `drv_dominant`=0 and `bus_bias_rec`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in | input | 1 | Host transmit line, 0 = dominant |
| bus_dom | input | 1 | Sampled receiver comparator, 1 = bus dominant |
| logic_sup_ok | input | 1 | Logic-side supply good |
| bus_sup_ok | input | 1 | Bus-side supply good |
| overtemp | input | 1 | Junction over-temperature flag |
| drv_en | output | 1 | Bus driver allowed |
| drv_dominant | output | 1 | Command the driver to dominant |
| bus_bias_rec | output | 1 | Bus left at recessive bias |
| rx_out | output | 1 | Receive line to host, 0 = dominant |
| rx_oe | output | 1 | Receive line drive enable, 0 = tristate |

## Verification
The hardest state to reach is a supply fault that lands in the middle of a recovery wait, because the recovery counter is hidden and only shows up as the edge on which `drv_en` comes back. The stimulus lets a recovery run partway and drops the bus-side supply for one cycle. It then counts edges until `drv_en` rises and expects exactly `REC_CYC` edges from the restore. The time-out and fail-safe boundaries get the same exact treatment: each is checked one cycle before and on the cycle it must act, counting from the negative edge where the stimulus was applied.

// File: rtl/can_guard_pkg.sv
package can_guard_pkg;

  typedef enum logic {
    SUP_HOLD = 1'b0,
    SUP_RUN  = 1'b1
  } sup_state_e;

  // Saturating increment used by every timer in the block.
  function automatic int unsigned sat_next(int unsigned c, int unsigned lim);
    return (c >= lim) ? lim : c + 1;
  endfunction

  // Width needed to hold values 0..lim.
  function automatic int unsigned cnt_bits(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/can_guard_txsync.sv
module can_guard_txsync (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_raw,
  output logic tx_s,
  output logic tx_fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= tx_raw;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign tx_s    = s2_q;
  assign tx_fall = prev_q & ~s2_q;

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (tx_s == $past(tx_raw, 2)));

endmodule

// File: rtl/can_guard_domtimer.sv
module can_guard_domtimer #(
  parameter int unsigned DTO_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_s,
  input  logic tx_fall,
  output logic dto_hit
);
  localparam int unsigned CW = can_guard_pkg::cnt_bits(DTO_CYC);
  localparam logic [CW-1:0] LIM = CW'(DTO_CYC);

  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
    end else if (tx_s) begin
      low_cnt_q <= '0;
    end else if (tx_fall) begin
      low_cnt_q <= CW'(1);
    end else begin
      low_cnt_q <= CW'(can_guard_pkg::sat_next(32'(low_cnt_q), DTO_CYC));
    end
  end

  assign dto_hit = (low_cnt_q == LIM);

  // R3
  dto_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dto_hit) |-> (!tx_s && $past(!tx_s)));

  // R4
  dto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_s |=> !dto_hit);

endmodule

// File: rtl/can_guard_supply.sv
module can_guard_supply #(
  parameter int unsigned FS_CYC  = 16,
  parameter int unsigned REC_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lsok,
  input  logic bsok,
  output logic sup_run,
  output logic seen_run,
  output logic fs_active
);
  import can_guard_pkg::*;

  localparam int unsigned RW = cnt_bits(REC_CYC);
  localparam int unsigned FW = cnt_bits(FS_CYC);
  localparam logic [RW-1:0] REC_LAST = RW'(REC_CYC - 1);
  localparam logic [FW-1:0] FS_LIM   = FW'(FS_CYC);

  sup_state_e    st_q;
  logic [RW-1:0] rec_cnt_q;
  logic [FW-1:0] fs_cnt_q;
  logic          seen_q;
  logic          both_ok;

  assign both_ok = lsok & bsok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SUP_HOLD;
      rec_cnt_q <= '0;
      seen_q    <= 1'b0;
    end else begin
      case (st_q)
        SUP_RUN: begin
          if (!both_ok) begin
            st_q      <= SUP_HOLD;
            rec_cnt_q <= '0;
          end
        end
        default: begin
          if (!both_ok) begin
            rec_cnt_q <= '0;
          end else if (rec_cnt_q == REC_LAST) begin
            st_q   <= SUP_RUN;
            seen_q <= 1'b1;
          end else begin
            rec_cnt_q <= RW'(sat_next(32'(rec_cnt_q), REC_CYC));
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_cnt_q <= '0;
    end else if (lsok && !bsok) begin
      fs_cnt_q <= FW'(sat_next(32'(fs_cnt_q), FS_CYC));
    end else begin
      fs_cnt_q <= '0;
    end
  end

  assign sup_run   = (st_q == SUP_RUN);
  assign seen_run  = seen_q;
  assign fs_active = (fs_cnt_q == FS_LIM);

  // R9
  run_needs_supplies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_run) |-> $past(both_ok));

  // R8
  failsafe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_active) |-> $past(lsok && !bsok));

  // R1
  seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_run |=> seen_run);

endmodule

// File: rtl/can_guard_ctrl.sv
module can_guard_ctrl #(
  parameter int unsigned DTO_CYC = 100,
  parameter int unsigned FS_CYC  = 16,
  parameter int unsigned REC_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_in,
  input  logic bus_dom,
  input  logic logic_sup_ok,
  input  logic bus_sup_ok,
  input  logic overtemp,
  output logic drv_en,
  output logic drv_dominant,
  output logic bus_bias_rec,
  output logic rx_out,
  output logic rx_oe
);
  logic tx_s, tx_fall, dto_hit;
  logic sup_run, seen_run, fs_active;
  logic ot_q;

  can_guard_txsync u_sync (
    .clk(clk), .rst_n(rst_n), .tx_raw(tx_in), .tx_s(tx_s), .tx_fall(tx_fall)
  );

  can_guard_domtimer #(.DTO_CYC(DTO_CYC)) u_dto (
    .clk(clk), .rst_n(rst_n), .tx_s(tx_s), .tx_fall(tx_fall), .dto_hit(dto_hit)
  );

  can_guard_supply #(.FS_CYC(FS_CYC), .REC_CYC(REC_CYC)) u_sup (
    .clk(clk), .rst_n(rst_n), .lsok(logic_sup_ok), .bsok(bus_sup_ok),
    .sup_run(sup_run), .seen_run(seen_run), .fs_active(fs_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ot_q <= 1'b1;
    else        ot_q <= overtemp;
  end

  assign drv_en       = sup_run & ~ot_q & ~dto_hit;
  assign drv_dominant = drv_en & ~tx_s;
  assign bus_bias_rec = ~drv_dominant;
  assign rx_oe        = logic_sup_ok;
  assign rx_out       = (!logic_sup_ok || !seen_run || fs_active) ? 1'b1 : ~bus_dom;

  // R5
  thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp |=> !drv_en);

  // R6
  rx_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dto_hit || ot_q) && seen_run && logic_sup_ok && !fs_active) |-> (rx_out == !bus_dom));

  // R7
  logic_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !logic_sup_ok |=> (bus_bias_rec && !drv_en));

  // R10
  bias_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_dominant |-> (!bus_bias_rec && drv_en));

endmodule

// File: tb/can_guard_ctrl_bench.sv
module can_guard_ctrl_bench;
  localparam int DTO = 20;
  localparam int FS  = 6;
  localparam int REC = 10;

  logic clk = 1'b0;
  logic rst_n, tx_in, bus_dom, ls_ok, bs_ok, ot;
  logic drv_en, drv_dominant, bus_bias_rec, rx_out, rx_oe;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  can_guard_ctrl #(.DTO_CYC(DTO), .FS_CYC(FS), .REC_CYC(REC)) u_can_guard_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .bus_dom(bus_dom),
    .logic_sup_ok(ls_ok), .bus_sup_ok(bs_ok), .overtemp(ot),
    .drv_en(drv_en), .drv_dominant(drv_dominant), .bus_bias_rec(bus_bias_rec),
    .rx_out(rx_out), .rx_oe(rx_oe)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_in = 1'b1; bus_dom = 1'b1; ls_ok = 1'b1; bs_ok = 1'b1; ot = 1'b0;
    tick(3);
    rst_n = 1'b1;
    check("R1", "drv_en at release", drv_en, 1'b0);
    check("R1", "rx_out at release", rx_out, 1'b1);
    for (int i = 1; i < REC; i++) begin
      tick();
      check("R1", "drv_en in wait", drv_en, 1'b0);
      check("R1", "rx_out in wait", rx_out, 1'b1);
    end
    tick();
    check("R1", "drv_en after wait", drv_en, 1'b1);
    check("R1", "rx_out mirrors bus", rx_out, 1'b0);
    check("R1", "rx_oe", rx_oe, 1'b1);
    bus_dom = 1'b0;
  endtask

  task automatic t_drive();
    tx_in = 1'b0;
    tick();
    check("R2", "dominant after 1 edge", drv_dominant, 1'b0);
    tick();
    check("R2", "dominant after 2 edges", drv_dominant, 1'b1);
    check("R10", "bias while dominant", bus_bias_rec, 1'b0);
    tx_in = 1'b1;
    tick();
    check("R2", "still dominant 1 edge after rise", drv_dominant, 1'b1);
    tick();
    check("R10", "recessive after rise", drv_dominant, 1'b0);
    check("R10", "bias recessive", bus_bias_rec, 1'b1);
    check("R10", "driver still enabled", drv_en, 1'b1);
  endtask

  task automatic t_timeout();
    tx_in = 1'b0;
    tick(DTO + 1);
    check("R3", "dominant at N-1", drv_dominant, 1'b1);
    tick();
    check("R3", "driver off at N", drv_en, 1'b0);
    check("R3", "no dominant at N", drv_dominant, 1'b0);
    check("R3", "bias recessive at N", bus_bias_rec, 1'b1);
    bus_dom = 1'b1; #1;
    check("R6", "rx follows bus in timeout", rx_out, 1'b0);
    bus_dom = 1'b0; #1;
    check("R6", "rx follows bus recessive", rx_out, 1'b1);
    tx_in = 1'b1;
    tick(2);
    check("R4", "still off before clear", drv_en, 1'b0);
    tick();
    check("R4", "driver back", drv_en, 1'b1);
    tx_in = 1'b0;
    tick(DTO + 1);
    check("R4", "fresh window N-1", drv_dominant, 1'b1);
    tick();
    check("R4", "fresh window expiry", drv_en, 1'b0);
    tx_in = 1'b1;
    tick(3);
  endtask

  task automatic t_thermal();
    tx_in = 1'b0;
    tick(2);
    check("R5", "dominant before overtemp", drv_dominant, 1'b1);
    ot = 1'b1;
    tick();
    check("R5", "driver off", drv_en, 1'b0);
    check("R5", "no dominant", drv_dominant, 1'b0);
    bus_dom = 1'b1; #1;
    check("R6", "rx follows bus in thermal", rx_out, 1'b0);
    bus_dom = 1'b0;
    ot = 1'b0;
    tick();
    check("R5", "driver back", drv_dominant, 1'b1);
    ot = 1'b1;
    tick();
    check("R5", "off again", drv_en, 1'b0);
    ot = 1'b0; tx_in = 1'b1;
    tick(3);
    check("R5", "enabled at end", drv_en, 1'b1);
  endtask

  task automatic t_logic_fault();
    ls_ok = 1'b0; #1;
    check("R7", "rx_oe same cycle", rx_oe, 1'b0);
    tick();
    check("R7", "driver off", drv_en, 1'b0);
    check("R7", "bias recessive", bus_bias_rec, 1'b1);
    ls_ok = 1'b1;
    tick(REC - 1);
    check("R9", "still waiting", drv_en, 1'b0);
    tick();
    check("R9", "back after REC", drv_en, 1'b1);
  endtask

  task automatic t_bus_fault();
    bs_ok = 1'b0; bus_dom = 1'b1;
    tick();
    check("R8", "driver off", drv_en, 1'b0);
    tick(FS - 2);
    check("R8", "rx follows at FS-1", rx_out, 1'b0);
    tick();
    check("R8", "rx forced high at FS", rx_out, 1'b1);
    check("R8", "rx_oe stays on", rx_oe, 1'b1);
    bs_ok = 1'b1; bus_dom = 1'b0;
    tick(REC / 2);
    bs_ok = 1'b0;
    tick();
    bs_ok = 1'b1;
    tick(REC - 1);
    check("R9", "restarted wait", drv_en, 1'b0);
    tick();
    check("R9", "back after restart", drv_en, 1'b1);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_drive();
    t_timeout();
    t_thermal();
    t_logic_fault();
    t_bus_fault();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule